// File: doc/BRIEF.md
# Symmetric PWM Generator with Conversion Triggers

This block produces two pulse-width-modulated outputs from a single counter that climbs from zero to a programmable top value and then descends back to zero. Each output is high while the counter sits above that output's compare value, so every pulse is centred on the top of the count. The instant the counter reaches zero falls in the middle of the low part of the cycle, and the instant it reaches the top falls in the middle of the high part. A converter that samples on these two instants therefore samples at the centre of each half-cycle at any duty.

The block reports six counter events: reaching zero, reaching the top, and each output's threshold crossed in the rising and in the falling direction. A mask selects the events that drive the single trigger line, and each selected event also sets a sticky status bit. New compare and top values go into holding registers first. A compare value is applied at the zero point or the top point, chosen by one control bit. A top value is applied only at the zero point. A fault input forces both outputs low straight away. The outputs stay low until the next zero point at which the fault is no longer present. One output can set the duty while the other acts only as an early trigger source, which covers a known conversion latency.

Top module: `cpwm_top`

## Requirements
- R1: While `gen_en` is low, `count` is 0, both outputs are low and `trig` stays low. Status bits are not set.
- R2: While enabled, `count` steps by exactly one each clock. It rises from 0 to the active top value T, falls back to 0 and repeats, so one period is 2*T clocks. T must be at least 1.
- R3: `pwm_a` is high exactly when enabled, `count` is above the active compare A value and no fault blanking applies. `pwm_b` follows the same rule with compare B.
- R4: A written compare value is held in a shadow register. It becomes active after the clock at the zero point when `sync_at_load` is 0, and after the clock at the top point when `sync_at_load` is 1. While the block is disabled, shadow values are applied every clock.
- R5: A written top value becomes active only after the clock at the zero point, or at once while disabled.
- R6: Event bit positions in `trig_mask` and `status` are fixed. Bit 0 is count equal to 0. Bit 1 is count equal to T while rising. Bit 2 is count equal to compare A plus 1 while rising. Bit 3 is count equal to compare A while falling. Bits 4 and 5 are the same two events for compare B.
- R7: `trig` is high in a cycle exactly when at least one event of that cycle has its mask bit set.
- R8: While `fault` is high, both outputs are low. After `fault` falls, they stay low until the clock at the next zero point with `fault` low has passed.
- R9: A masked event sets its `status` bit on the next clock. A bit stays set until a one is written to the same bit of `clr_status`. When an event and a clear hit the same bit on the same clock, the event wins.
- R10: On the first enabled cycle `count` is 0 and rising. The zero event fires in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator enable |
| sync_at_load | input | 1 | Compare update point: 0 zero point, 1 top point |
| load_wr | input | 1 | Write strobe for the top value |
| load_val | input | W | New top value |
| cmpa_wr | input | 1 | Write strobe for compare A |
| cmpa_val | input | W | New compare A value |
| cmpb_wr | input | 1 | Write strobe for compare B |
| cmpb_val | input | W | New compare B value |
| trig_mask | input | 6 | Event enable mask (bit positions per R6) |
| clr_status | input | 6 | Write-one-to-clear for status bits |
| fault | input | 1 | Fault input, blanks outputs |
| count | output | W | Current counter value |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| trig | output | 1 | OR of masked events |
| status | output | 6 | Sticky event flags |

## Verification
The bench builds the block with W = 8 and uses top values from 2 to 10. This keeps whole periods short, so one run can walk many full up/down cycles for each configuration. The small width allows compare values at zero, at T-1, at T and far above T. These cover the single-clock pulse, the never-high output and the crossings that fire next to the zero and top points. The same short periods let a mid-period compare write, a top change and a fault pulse each be followed into the next boundary within a few dozen clocks.

// File: rtl/cpwm_pkg.sv
// Shared definitions for the symmetric PWM generator.
// Event bit positions are fixed because the trigger mask and status use them.
package cpwm_pkg;
    localparam int NEVT = 6;

    typedef enum int unsigned {
        EV_ZERO = 0,
        EV_TOP  = 1,
        EV_AUP  = 2,
        EV_ADN  = 3,
        EV_BUP  = 4,
        EV_BDN  = 5
    } evt_idx_e;
endpackage

// File: rtl/cpwm_counter.sv
// Up/down counter between zero and a double-buffered top value.
// Assumes the active top value is at least 1. The direction flips on the
// clock at zero and at top, so each of those values lasts one cycle.
module cpwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load_wr,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         dir_up,
    output logic         zero_evt,
    output logic         top_evt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] top_sh_q;
    logic [W-1:0] top_act_q;

    assign zero_evt = en && (count == '0);
    assign top_evt  = en && dir_up && (count == top_act_q);

    // Capture writes into the top-value shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)       top_sh_q <= '0;
        else if (load_wr) top_sh_q <= load_val;
    end

    // Apply the shadow top value at the zero point or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 top_act_q <= '0;
        else if (!en || zero_evt)   top_act_q <= top_sh_q;
    end

    // Step the counter and turn it around at zero and at top.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            count  <= '0;
            dir_up <= 1'b1;
        end else if (dir_up) begin
            if (count == top_act_q) begin
                dir_up <= 1'b0;
                count  <= count - ONE;
            end else begin
                count  <= count + ONE;
            end
        end else begin
            if (count == '0) begin
                dir_up <= 1'b1;
                count  <= count + ONE;
            end else begin
                count  <= count - ONE;
            end
        end
    end
endmodule

// File: rtl/cpwm_cmp_chan.sv
// One compare channel: shadow and active compare value, output level and
// the two direction-qualified crossing events. The rising event fires on the
// cycle where the count first exceeds the compare value, and the falling
// event fires on the cycle where the count drops back to it. Both match the
// output edges.
module cpwm_cmp_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_val,
    input  logic         upd,
    input  logic [W-1:0] count,
    input  logic         dir_up,
    output logic         above,
    output logic         ev_up,
    output logic         ev_dn
);
    localparam int WX = W + 1;

    logic [W-1:0] sh_q;
    logic [W-1:0] act_q;

    // Hold newly written compare values.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (cmp_wr) sh_q <= cmp_val;
    end

    // Transfer the shadow at the selected boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)           act_q <= '0;
        else if (!en || upd)  act_q <= sh_q;
    end

    assign above = en && (count > act_q);
    assign ev_up = en && dir_up  && ({1'b0, count} == ({1'b0, act_q} + WX'(1)));
    assign ev_dn = en && !dir_up && (count == act_q);
endmodule

// File: rtl/cpwm_trig.sv
// Masks the event vector onto one trigger line and keeps sticky flags.
// Assumes events are already single-cycle pulses.
module cpwm_trig #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic         trig,
    output logic [N-1:0] status
);
    logic [N-1:0] hit;

    assign hit  = evt & mask;
    assign trig = |hit;

    // Sticky flags; a new hit outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | hit;
    end
endmodule

// File: rtl/cpwm_top.sv
// Symmetric PWM generator with masked conversion triggers and
// cycle-by-cycle fault blanking. Assumes the programmed top value is >= 1.
module cpwm_top #(
    parameter int W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         gen_en,
    input  logic                         sync_at_load,
    input  logic                         load_wr,
    input  logic [W-1:0]                 load_val,
    input  logic                         cmpa_wr,
    input  logic [W-1:0]                 cmpa_val,
    input  logic                         cmpb_wr,
    input  logic [W-1:0]                 cmpb_val,
    input  logic [cpwm_pkg::NEVT-1:0]    trig_mask,
    input  logic [cpwm_pkg::NEVT-1:0]    clr_status,
    input  logic                         fault,
    output logic [W-1:0]                 count,
    output logic                         pwm_a,
    output logic                         pwm_b,
    output logic                         trig,
    output logic [cpwm_pkg::NEVT-1:0]    status
);
    import cpwm_pkg::*;

    localparam int NCH = 2;

    logic                 dir_up;
    logic                 zero_evt;
    logic                 top_evt;
    logic                 upd;
    logic                 blank_q;
    logic [NCH-1:0]       ch_wr;
    logic [W-1:0]         ch_val [NCH];
    logic [NCH-1:0]       ch_above;
    logic [NCH-1:0]       ch_up;
    logic [NCH-1:0]       ch_dn;
    logic [NEVT-1:0]      evt;

    assign ch_wr     = {cmpb_wr, cmpa_wr};
    assign ch_val[0] = cmpa_val;
    assign ch_val[1] = cmpb_val;
    assign upd       = sync_at_load ? top_evt : zero_evt;

    cpwm_counter #(.W(W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gen_en),
        .load_wr  (load_wr),
        .load_val (load_val),
        .count    (count),
        .dir_up   (dir_up),
        .zero_evt (zero_evt),
        .top_evt  (top_evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cpwm_cmp_chan #(.W(W)) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (gen_en),
            .cmp_wr  (ch_wr[g]),
            .cmp_val (ch_val[g]),
            .upd     (upd),
            .count   (count),
            .dir_up  (dir_up),
            .above   (ch_above[g]),
            .ev_up   (ch_up[g]),
            .ev_dn   (ch_dn[g])
        );
    end

    // Assemble the event vector in its fixed bit order.
    always_comb begin
        evt          = '0;
        evt[EV_ZERO] = zero_evt;
        evt[EV_TOP]  = top_evt;
        evt[EV_AUP]  = ch_up[0];
        evt[EV_ADN]  = ch_dn[0];
        evt[EV_BUP]  = ch_up[1];
        evt[EV_BDN]  = ch_dn[1];
    end

    // Blanking latch: set by fault, released at a fault-free zero point.
    always_ff @(posedge clk) begin
        if (!rst_n || !gen_en) blank_q <= 1'b0;
        else if (fault)        blank_q <= 1'b1;
        else if (zero_evt)     blank_q <= 1'b0;
    end

    assign pwm_a = ch_above[0] && !fault && !blank_q;
    assign pwm_b = ch_above[1] && !fault && !blank_q;

    cpwm_trig #(.N(NEVT)) i_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .mask   (trig_mask),
        .clr    (clr_status),
        .trig   (trig),
        .status (status)
    );
endmodule

// File: rtl/cpwm_checker.sv
// Property checker for cpwm_top, attached by bind below.
module cpwm_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         gen_en,
    input logic         fault,
    input logic [5:0]   clr_status,
    input logic [W-1:0] count,
    input logic         pwm_a,
    input logic         pwm_b,
    input logic         trig,
    input logic [5:0]   status
);
    localparam logic [W-1:0] ONE = W'(1);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |-> (!pwm_a && !pwm_b && !trig));

    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && $past(gen_en) && $past(rst_n)) |->
        (count == $past(count) + ONE || count == $past(count) - ONE));

    a_r3_low_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_a || pwm_b) |-> (count != '0));

    a_r8_fault_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!pwm_a && !pwm_b));

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(status) & ~$past(clr_status)) & ~status) == 6'b0));

    a_r10_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_en) |-> (count == '0));
endmodule

bind cpwm_top cpwm_checker #(.W(W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .fault      (fault),
    .clr_status (clr_status),
    .count      (count),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .trig       (trig),
    .status     (status)
);

// File: tb/test_cpwm_top.sv
`timescale 1ns/1ps
module test_cpwm_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gen_en = 1'b0;
    logic         sync_at_load = 1'b0;
    logic         load_wr = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         cmpa_wr = 1'b0;
    logic [W-1:0] cmpa_val = '0;
    logic         cmpb_wr = 1'b0;
    logic [W-1:0] cmpb_val = '0;
    logic [5:0]   trig_mask = '0;
    logic [5:0]   clr_status = '0;
    logic         fault = 1'b0;
    logic [W-1:0] count;
    logic         pwm_a;
    logic         pwm_b;
    logic         trig;
    logic [5:0]   status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Vector: {sync, mask(8), cmpb, cmpa, top}
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {8'd0, 8'b0000_0011, 8'd1,  8'd3, 8'd6},
        {8'd1, 8'b0011_1100, 8'd4,  8'd0, 8'd5},
        {8'd0, 8'b0011_1111, 8'd7,  8'd8, 8'd8},
        {8'd1, 8'b0001_0101, 8'd0,  8'd1, 8'd2},
        {8'd0, 8'b0000_1100, 8'd20, 8'd9, 8'd10},
        {8'd0, 8'b0000_0000, 8'd2,  8'd2, 8'd3}
    };

    cpwm_top #(.W(W)) i_cpwm_top (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .sync_at_load(sync_at_load),
        .load_wr(load_wr), .load_val(load_val), .cmpa_wr(cmpa_wr), .cmpa_val(cmpa_val),
        .cmpb_wr(cmpb_wr), .cmpb_val(cmpb_val), .trig_mask(trig_mask),
        .clr_status(clr_status), .fault(fault), .count(count), .pwm_a(pwm_a),
        .pwm_b(pwm_b), .trig(trig), .status(status)
    );

    always #2.5 clk = ~clk;

    // Reference model state, built from the requirements.
    int m_c, m_top, m_topsh, m_ca, m_cash, m_cb, m_cbsh;
    bit m_up, m_blank;
    logic [5:0] m_stat;

    function automatic logic [5:0] m_evt();
        logic [5:0] e;
        e[0] = gen_en && m_c == 0;
        e[1] = gen_en && m_up && m_c == m_top;
        e[2] = gen_en && m_up && m_c == m_ca + 1;
        e[3] = gen_en && !m_up && m_c == m_ca;
        e[4] = gen_en && m_up && m_c == m_cb + 1;
        e[5] = gen_en && !m_up && m_c == m_cb;
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c = 0; m_up = 1; m_top = 0; m_topsh = 0; m_ca = 0; m_cash = 0;
            m_cb = 0; m_cbsh = 0; m_blank = 0; m_stat = '0;
        end else begin
            logic [5:0] e;
            bit bnd;
            e = m_evt();
            m_stat = (m_stat & ~clr_status) | (e & trig_mask);
            if (!gen_en) m_blank = 0;
            else if (fault) m_blank = 1;
            else if (e[0]) m_blank = 0;
            bnd = sync_at_load ? e[1] : e[0];
            if (!gen_en || bnd) begin m_ca = m_cash; m_cb = m_cbsh; end
            if (cmpa_wr) m_cash = int'(cmpa_val);
            if (cmpb_wr) m_cbsh = int'(cmpb_val);
            if (!gen_en) begin m_c = 0; m_up = 1; end
            else if (m_up) begin
                if (m_c == m_top) begin m_up = 0; m_c = m_c - 1; end
                else m_c = m_c + 1;
            end else begin
                if (m_c == 0) begin m_up = 1; m_c = m_c + 1; end
                else m_c = m_c - 1;
            end
            if (!gen_en || e[0]) m_top = m_topsh;
            if (load_wr) m_topsh = int'(load_val);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output against the model, away from the clock edge.
    task automatic cmp_all();
        logic [5:0] e;
        bit ea, eb;
        e  = m_evt();
        ea = gen_en && m_c > m_ca && !fault && !m_blank;
        eb = gen_en && m_c > m_cb && !fault && !m_blank;
        chk(int'(count) == m_c, "R2/R10 count", int'(count), m_c);
        chk(pwm_a == ea, "R3/R4/R5/R8 pwm_a", pwm_a, ea);
        chk(pwm_b == eb, "R3/R4/R5/R8 pwm_b", pwm_b, eb);
        chk(trig == |(e & trig_mask), "R6/R7 trig", trig, |(e & trig_mask));
        chk(status == m_stat, "R9 status", status, m_stat);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
        load_wr = 0; cmpa_wr = 0; cmpb_wr = 0; clr_status = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(count == '0 && !pwm_a && !pwm_b && !trig, "R1 reset outputs", int'(count), 0);
        chk(status == '0, "R9 reset status", status, 0);

        // Table walk: each configuration applied while idle, then run.
        for (int v = 0; v < NV; v++) begin
            gen_en = 0;
            load_val = VEC[v][7:0]; load_wr = 1;
            cmpa_val = VEC[v][15:8]; cmpa_wr = 1;
            cmpb_val = VEC[v][23:16]; cmpb_wr = 1;
            trig_mask = VEC[v][29:24];
            sync_at_load = VEC[v][32];
            clr_status = '1;
            tick(); tick(); tick();
            gen_en = 1;
            for (int k = 0; k < 60; k++) tick();
        end

        // R4: compare write mid-period, applied at zero point.
        gen_en = 0; sync_at_load = 0; trig_mask = 6'b001111;
        load_val = 6; load_wr = 1; cmpa_val = 2; cmpa_wr = 1; cmpb_val = 3; cmpb_wr = 1;
        tick(); tick();
        gen_en = 1;
        tick(); tick(); tick();
        cmpa_val = 5; cmpa_wr = 1;
        for (int k = 0; k < 30; k++) tick();
        // R4: same with top-point update.
        sync_at_load = 1; cmpa_val = 1; cmpa_wr = 1;
        for (int k = 0; k < 30; k++) tick();

        // R5: top value changed mid-run.
        load_val = 4; load_wr = 1;
        for (int k = 0; k < 30; k++) tick();

        // R8: fault while output A is high, then released before the zero point.
        cmpa_val = 0; cmpa_wr = 1;
        for (int k = 0; k < 30; k++) begin
            tick();
            if (count == 8'd2 && pwm_a) break;
        end
        fault = 1;
        tick();
        chk(!pwm_a && !pwm_b, "R8 during fault", pwm_a, 0);
        fault = 0;
        tick();
        chk(!pwm_a, "R8 blank after fault", pwm_a, 0);
        for (int k = 0; k < 20; k++) tick();

        // R9: clear all flags with the mask off.
        trig_mask = '0; clr_status = '1;
        tick();
        chk(status == '0, "R9 cleared", status, 0);
        // R9: set wins over clear on the same clock.
        trig_mask = 6'b000001;
        for (int k = 0; k < 20; k++) begin
            if (count == '0) clr_status = 6'b000001;
            tick();
        end

        // R1: disable mid-run, outputs and trigger idle.
        trig_mask = '1;
        gen_en = 0;
        tick();
        chk(!pwm_a && !pwm_b && !trig && count == '0, "R1 disabled idle", int'(count), 0);
        for (int k = 0; k < 5; k++) tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule